// File: doc/BRIEF.md
# Run-Time Width Vector Element Adder

This block adds two 128-bit vector operands lane by lane. The element width is picked at run time from a 3-bit width code, and can be 8, 16, 32 or 64 bits. The sixteen bytes of each operand are regrouped into elements of that width, with element 0 in the least significant bytes. Only the first `vl` element pairs are added. The destination register keeps its old contents in every lane at index `vl` and above.

A start strobe captures both sources, the width and grouping codes, and the requested element count. The block then works through one element per clock cycle and builds the result in a working copy of the destination. It commits the whole register in one step when the last element is done, and pulses a done flag in that same cycle. Two cases complete at once without touching the destination: a zero element count, and an unsupported configuration. An unsupported configuration also raises an illegal flag.

Top module: `vec_elem_adder`

## Requirements
- R1: While reset is held and after it is released, `dest_o` reads 0 and `done_o` and `illegal_o` read 0.
- R2: Width code `sew_i` 3'b000, 3'b001, 3'b010 and 3'b011 selects 8, 16, 32 and 64-bit elements. Element i occupies bits [(i+1)*W-1 : i*W] of each operand and of `dest_o`.
- R3: Each element sum wraps modulo 2^W, and no carry crosses from one element into the next.
- R4: Destination elements at index vl and above keep the value `dest_o` held before the start (tail undisturbed).
- R5: The effective count is min(`vl_i`, 128/W). A larger `vl_i` processes every element of the register.
- R6: With a legal configuration and `vl_i` = 0, `done_o` rises in the cycle after the start edge, `dest_o` does not change and `illegal_o` stays 0.
- R7: A `sew_i` above 3'b011, or an `lmul_i` other than 3'b000, raises `illegal_o` together with `done_o` in the cycle after the start edge, and `dest_o` does not change.
- R8: A legal operation with effective count n > 0 raises `done_o` for exactly one cycle, n clock edges after the start edge. `dest_o` takes the full result at that same edge and changes at no other time.
- R9: Sources and configuration are sampled at the start edge. Input changes and extra start strobes while an operation runs have no effect on it.
- R10: A start presented in the cycle where `done_o` is high is accepted. The new operation uses the just-committed `dest_o` as its tail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, accepted when idle |
| src_a_i | input | 128 | First source vector |
| src_b_i | input | 128 | Second source vector |
| sew_i | input | 3 | Element width code |
| lmul_i | input | 3 | Register grouping code; only 3'b000 is legal |
| vl_i | input | 5 | Requested element count |
| dest_o | output | 128 | Destination vector |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Unsupported configuration, valid with done_o |

## Verification
Two functions can fall in the same cycle: the commit of a finished result with its done pulse, and the acceptance of a new start. The bench provokes this by raising the next start on the very cycle where done is seen. It then judges the second result: that result's tail lanes must equal the first operation's committed value, and its latency must be normal. A second overlap is a start strobe, together with changed operands, landing in the middle of a running operation. It is judged by a result and latency that are unchanged from the undisturbed case.

// File: rtl/vadd_pkg.sv
package vadd_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEW_W  = 3;
  localparam int unsigned LMUL_W = 3;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vadd_state_e;

endpackage

// File: rtl/vadd_cfg_decode.sv
module vadd_cfg_decode
  import vadd_pkg::*;
#(
  parameter int unsigned NBYTES       = 16,
  parameter int unsigned VL_W         = 5,
  parameter int unsigned MAX_SEW_CODE = 3
) (
  input  logic [SEW_W-1:0]  sew_i,
  input  logic [LMUL_W-1:0] lmul_i,
  input  logic [VL_W-1:0]   vl_i,
  output logic              legal_o,
  output logic [VL_W-1:0]   vl_eff_o
);

  localparam logic [SEW_W-1:0] SEW_LIMIT = SEW_W'(MAX_SEW_CODE);
  localparam logic [VL_W-1:0]  ALL_BYTES = VL_W'(NBYTES);

  logic [VL_W-1:0] max_elems;

  always_comb begin
    legal_o   = (sew_i <= SEW_LIMIT) && (lmul_i == '0);
    max_elems = ALL_BYTES >> sew_i;
    if (vl_i > max_elems) begin
      vl_eff_o = max_elems;
    end else begin
      vl_eff_o = vl_i;
    end
  end

endmodule

// File: rtl/vadd_seg_adder.sv
module vadd_seg_adder
  import vadd_pkg::*;
#(
  parameter int unsigned NBYTES = 16
) (
  input  logic [NBYTES*BYTE_W-1:0] opa_i,
  input  logic [NBYTES*BYTE_W-1:0] opb_i,
  input  logic [SEW_W-1:0]         sew_i,
  output logic [NBYTES*BYTE_W-1:0] sum_o
);

  logic [7:0]        grp_mask;
  logic [NBYTES-1:0] carry;

  assign grp_mask = (8'd1 << sew_i) - 8'd1;

  for (genvar j = 0; j < NBYTES; j++) begin : g_byte
    logic        cin;
    logic [BYTE_W:0] part;
    if (j == 0) begin : g_first
      assign cin = 1'b0;
    end else begin : g_chain
      assign cin = ((8'(j) & grp_mask) == 8'd0) ? 1'b0 : carry[j-1];
    end
    assign part = {1'b0, opa_i[j*BYTE_W +: BYTE_W]}
                + {1'b0, opb_i[j*BYTE_W +: BYTE_W]}
                + {{BYTE_W{1'b0}}, cin};
    assign sum_o[j*BYTE_W +: BYTE_W] = part[BYTE_W-1:0];
    assign carry[j] = part[BYTE_W];
  end

endmodule

// File: rtl/vadd_lane_select.sv
module vadd_lane_select
  import vadd_pkg::*;
#(
  parameter int unsigned NBYTES = 16,
  parameter int unsigned VL_W   = 5
) (
  input  logic [VL_W-1:0]          idx_i,
  input  logic [SEW_W-1:0]         sew_i,
  output logic [NBYTES*BYTE_W-1:0] mask_o
);

  for (genvar j = 0; j < NBYTES; j++) begin : g_lane
    logic hit;
    assign hit = ((8'(j) >> sew_i) == 8'(idx_i));
    assign mask_o[j*BYTE_W +: BYTE_W] = {BYTE_W{hit}};
  end

endmodule

// File: rtl/vadd_ctrl.sv
module vadd_ctrl
  import vadd_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned VL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cfg_legal_i,
  input  logic [VL_W-1:0]   vl_eff_i,
  input  logic [VLEN-1:0]   src_a_i,
  input  logic [VLEN-1:0]   src_b_i,
  input  logic [SEW_W-1:0]  sew_i,
  input  logic [VLEN-1:0]   sum_i,
  input  logic [VLEN-1:0]   lane_mask_i,
  output logic [VLEN-1:0]   opa_o,
  output logic [VLEN-1:0]   opb_o,
  output logic [SEW_W-1:0]  sew_o,
  output logic [VL_W-1:0]   idx_o,
  output logic [VLEN-1:0]   dest_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              busy_o
);

  vadd_state_e      state_q, state_d;
  logic [VLEN-1:0]  opa_q, opb_q, work_q, work_d, dest_q, merged;
  logic [SEW_W-1:0] sew_q;
  logic [VL_W-1:0]  vl_q, idx_q, idx_d;
  logic             done_q, done_d, illegal_q, illegal_d;
  logic             cap_en, run, last, work_en, dest_en;

  assign cap_en = start_i && (state_q == ST_IDLE);
  assign run    = (state_q == ST_RUN);
  assign last   = (idx_q == (vl_q - VL_W'(1)));
  assign merged = (work_q & ~lane_mask_i) | (sum_i & lane_mask_i);
  assign work_en = cap_en || run;

  always_comb begin
    state_d   = state_q;
    done_d    = 1'b0;
    illegal_d = 1'b0;
    work_d    = work_q;
    idx_d     = idx_q;
    dest_en   = 1'b0;
    if (cap_en) begin
      work_d = dest_q;
      idx_d  = '0;
      if (!cfg_legal_i || (vl_eff_i == '0)) begin
        done_d    = 1'b1;
        illegal_d = !cfg_legal_i;
      end else begin
        state_d = ST_RUN;
      end
    end else if (run) begin
      work_d = merged;
      idx_d  = idx_q + VL_W'(1);
      if (last) begin
        dest_en = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      opa_q     <= '0;
      opb_q     <= '0;
      sew_q     <= '0;
      vl_q      <= '0;
      idx_q     <= '0;
      work_q    <= '0;
      dest_q    <= '0;
    end else begin
      state_q   <= state_d;
      done_q    <= done_d;
      illegal_q <= illegal_d;
      if (cap_en) begin
        opa_q <= src_a_i;
        opb_q <= src_b_i;
        sew_q <= sew_i;
        vl_q  <= vl_eff_i;
      end
      if (work_en) begin
        work_q <= work_d;
        idx_q  <= idx_d;
      end
      if (dest_en) begin
        dest_q <= merged;
      end
    end
  end

  assign opa_o     = opa_q;
  assign opb_o     = opb_q;
  assign sew_o     = sew_q;
  assign idx_o     = idx_q;
  assign dest_o    = dest_q;
  assign done_o    = done_q;
  assign illegal_o = illegal_q;
  assign busy_o    = run;

endmodule

// File: rtl/vec_elem_adder.sv
module vec_elem_adder
  import vadd_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [VLEN-1:0]   src_a_i,
  input  logic [VLEN-1:0]   src_b_i,
  input  logic [SEW_W-1:0]  sew_i,
  input  logic [LMUL_W-1:0] lmul_i,
  input  logic [$clog2(VLEN/BYTE_W):0] vl_i,
  output logic [VLEN-1:0]   dest_o,
  output logic              done_o,
  output logic              illegal_o
);

  localparam int unsigned NBYTES       = VLEN / BYTE_W;
  localparam int unsigned VL_W         = $clog2(NBYTES) + 1;
  localparam int unsigned MAX_SEW_CODE = $clog2(ELEN / BYTE_W);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             cfg_legal;
  logic [VL_W-1:0]  vl_eff;
  logic [VLEN-1:0]  opa, opb, sum, lane_mask;
  logic [SEW_W-1:0] sew_run;
  logic [VL_W-1:0]  idx;
  logic             busy_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  vadd_cfg_decode #(
    .NBYTES(NBYTES), .VL_W(VL_W), .MAX_SEW_CODE(MAX_SEW_CODE)
  ) u_decode (
    .sew_i(sew_i), .lmul_i(lmul_i), .vl_i(vl_i),
    .legal_o(cfg_legal), .vl_eff_o(vl_eff)
  );

  vadd_seg_adder #(.NBYTES(NBYTES)) u_adder (
    .opa_i(opa), .opb_i(opb), .sew_i(sew_run), .sum_o(sum)
  );

  vadd_lane_select #(.NBYTES(NBYTES), .VL_W(VL_W)) u_lanes (
    .idx_i(idx), .sew_i(sew_run), .mask_o(lane_mask)
  );

  vadd_ctrl #(.VLEN(VLEN), .VL_W(VL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i),
    .cfg_legal_i(cfg_legal), .vl_eff_i(vl_eff),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .sew_i(sew_i),
    .sum_i(sum), .lane_mask_i(lane_mask),
    .opa_o(opa), .opb_o(opb), .sew_o(sew_run), .idx_o(idx),
    .dest_o(dest_o), .done_o(done_o), .illegal_o(illegal_o),
    .busy_o(busy_w)
  );

endmodule

// File: rtl/vadd_checker.sv
module vadd_checker #(
  parameter int unsigned VLEN         = 128,
  parameter int unsigned VL_W         = 5,
  parameter logic [2:0]  MAX_SEW_CODE = 3'd3
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            start_i,
  input logic [2:0]      sew_i,
  input logic [2:0]      lmul_i,
  input logic [VL_W-1:0] vl_i,
  input logic [VLEN-1:0] dest_o,
  input logic            done_o,
  input logic            illegal_o,
  input logic            busy_w
);

  // R8: the destination only moves on a completion cycle
  assert_dest_moves_on_done_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(dest_o) |-> done_o);

  // R8: completion leaves the block idle
  assert_done_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> !busy_w);

  // R7: illegal configuration completes at once and keeps the destination
  assert_illegal_fast_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !busy_w && ((sew_i > MAX_SEW_CODE) || (lmul_i != 3'd0))) |=> (illegal_o && done_o));

  assert_illegal_keeps_dest_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    illegal_o |-> ($stable(dest_o) && done_o));

  // R6: zero count completes in one cycle
  assert_zero_vl_done_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !busy_w && (vl_i == '0)) |=> done_o);

endmodule

bind vec_elem_adder vadd_checker #(
  .VLEN(VLEN), .VL_W(VL_W), .MAX_SEW_CODE(3'(MAX_SEW_CODE))
) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .start_i(start_i), .sew_i(sew_i),
  .lmul_i(lmul_i), .vl_i(vl_i), .dest_o(dest_o), .done_o(done_o),
  .illegal_o(illegal_o), .busy_w(busy_w)
);

// File: tb/vec_elem_adder_tb_top.sv
module vec_elem_adder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  localparam logic [2:0]   T_SEW [NVEC] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd0, 3'd3, 3'd2};
  localparam logic [4:0]   T_VL  [NVEC] = '{5'd16, 5'd8, 5'd3, 5'd2, 5'd20, 5'd9, 5'd1};
  localparam int           T_LAT [NVEC] = '{17, 9, 4, 3, 17, 3, 2};
  localparam logic [127:0] T_A [NVEC] = '{
    128'hFF80_7F01_FFFE_0010_8081_C3A5_0F0F_FFFF,
    128'hFFFF_8000_1234_0001_FFFF_7FFF_ABCD_00FF,
    128'h1111_1111_FFFF_FFFF_8000_0000_0000_0001,
    128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
    128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10,
    128'h8000_0000_0000_0000_7FFF_FFFF_FFFF_FFFF,
    128'hDEAD_BEEF_0000_0000_0000_0000_0000_0005};
  localparam logic [127:0] T_B [NVEC] = '{
    128'h0180_8101_0102_F0F0_8080_3D5B_F1F1_0101,
    128'h0001_8000_EDCC_FFFF_0002_0001_5433_FF01,
    128'h2222_2222_0000_0001_8000_0000_FFFF_FFFF,
    128'h0000_0000_0000_0001_0000_0000_0000_0001,
    128'hF0E0_D0C0_B0A0_9080_7060_5040_3020_1000,
    128'h8000_0000_0000_0000_0000_0000_0000_0001,
    128'h0000_0000_0000_0000_0000_0000_FFFF_FFFE};
  localparam string T_TAG [NVEC] = '{"R3 e8 wrap", "R2 e16", "R4 e32 tail",
    "R3 e64 no cross carry", "R5 clamp e8", "R5 clamp e64", "R4 e32 single"};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] src_a_i = '0, src_b_i = '0;
  logic [2:0]   sew_i = '0, lmul_i = '0;
  logic [4:0]   vl_i = '0;
  logic [127:0] dest_o;
  logic         done_o, illegal_o;

  int checks = 0;
  int failures = 0;
  logic [127:0] exp_dest = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_elem_adder dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .sew_i(sew_i), .lmul_i(lmul_i), .vl_i(vl_i),
    .dest_o(dest_o), .done_o(done_o), .illegal_o(illegal_o)
  );

  function automatic logic [127:0] model(input logic [127:0] prev, a, b,
                                          input logic [2:0] sew, lmul,
                                          input logic [4:0] vl);
    int w, n, veff;
    logic [127:0] m, r, ea, eb, s;
    if (sew > 3'd3 || lmul != 3'd0) return prev;
    w = 8 << sew;
    n = 16 >> sew;
    veff = (int'(vl) > n) ? n : int'(vl);
    m = {128{1'b1}} >> (128 - w);
    r = prev;
    for (int i = 0; i < veff; i++) begin
      ea = (a >> (i * w)) & m;
      eb = (b >> (i * w)) & m;
      s  = (ea + eb) & m;
      r  = (r & ~(m << (i * w))) | (s << (i * w));
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic issue(input logic [127:0] a, b, input logic [2:0] sew, lmul,
                       input logic [4:0] vl);
    src_a_i = a; src_b_i = b; sew_i = sew; lmul_i = lmul; vl_i = vl;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int cnt, input bit disturb);
    cnt = 1;
    while (!done_o && cnt < 40) begin
      if (disturb && cnt == 2) begin
        src_a_i = ~src_a_i; src_b_i = 128'h5; sew_i = 3'd2; vl_i = 5'd1;
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start_i = 1'b0;
  endtask

  task automatic finish_op(input int cnt, input int exp_lat, input logic [127:0] expd,
                           input bit exp_ill, input string tag, input bit chk_drop);
    check(cnt == exp_lat, {tag, " R8 latency"}, 128'(cnt), 128'(exp_lat));
    check(dest_o == expd, {tag, " dest"}, dest_o, expd);
    check(illegal_o == exp_ill, {tag, " illegal flag"}, 128'(illegal_o), 128'(exp_ill));
    exp_dest = expd;
    if (chk_drop) begin
      @(negedge clk);
      check(done_o == 1'b0, {tag, " R8 done single cycle"}, 128'(done_o), 128'd0);
    end
  endtask

  task automatic run_op(input logic [127:0] a, b, input logic [2:0] sew, lmul,
                        input logic [4:0] vl, input int exp_lat, input bit exp_ill,
                        input string tag, input bit disturb);
    int cnt;
    logic [127:0] expd;
    expd = model(exp_dest, a, b, sew, lmul, vl);
    @(negedge clk);
    issue(a, b, sew, lmul, vl);
    wait_done(cnt, disturb);
    finish_op(cnt, exp_lat, expd, exp_ill, tag, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    logic [127:0] e1, e2;
    repeat (3) @(negedge clk);
    check(dest_o == '0 && !done_o && !illegal_o, "R1 outputs during reset", dest_o, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dest_o == '0 && !done_o && !illegal_o, "R1 outputs after reset", dest_o, '0);

    for (int k = 0; k < NVEC; k++) begin
      run_op(T_A[k], T_B[k], T_SEW[k], 3'd0, T_VL[k], T_LAT[k], 1'b0, T_TAG[k], 1'b0);
    end

    // R6: zero count
    run_op(128'h1234, 128'h1, 3'd1, 3'd0, 5'd0, 1, 1'b0, "R6 zero vl", 1'b0);
    // R7: reserved width code and nonzero grouping
    run_op(128'hFF, 128'hFF, 3'd5, 3'd0, 5'd4, 1, 1'b1, "R7 bad sew", 1'b0);
    run_op(128'hFF, 128'hFF, 3'd0, 3'd1, 5'd4, 1, 1'b1, "R7 bad lmul", 1'b0);
    // R9: disturbance while running
    run_op(128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_01FF, {16{8'h11}}, 3'd0, 3'd0,
           5'd10, 11, 1'b0, "R9 inputs ignored while busy", 1'b1);

    // R10: start on the done cycle, tail taken from just-committed value
    e1 = model(exp_dest, {16{8'h7F}}, {16{8'h02}}, 3'd0, 3'd0, 5'd4);
    @(negedge clk);
    issue({16{8'h7F}}, {16{8'h02}}, 3'd0, 3'd0, 5'd4);
    wait_done(cnt, 1'b0);
    finish_op(cnt, 5, e1, 1'b0, "R10 first op", 1'b0);
    e2 = model(e1, 128'hFFFF_0001, 128'h0001_FFFF, 3'd1, 3'd0, 5'd2);
    issue(128'hFFFF_0001, 128'h0001_FFFF, 3'd1, 3'd0, 5'd2);
    wait_done(cnt, 1'b0);
    finish_op(cnt, 3, e2, 1'b0, "R10 back-to-back op", 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule